// File: doc/BRIEF.md
# Input Capture Interval Timer

An 8-bit up-counting timer with a small synchronous register bus. A free-running prescaler divides the system clock, and a two-bit select chooses one of four tick rates. Each tick adds one to the counter while the timer's run bit is set. The counter wraps from 0xFF to 0x00. Each wrap can raise an overflow flag and, through a second enable, an interrupt line. Software cannot see the counter on the bus.

A mode bit picks between two behaviours. In interval mode the counter runs freely and the capture pin has no effect. In capture mode the pin is synchronized and its edges are detected. A rising edge copies the counter into one capture register and a falling edge copies it into another. The counter can also be cleared on a chosen edge. The internal capture signal is the synchronized pin ANDed with the mode bit. A mode change while the pin is high therefore acts as an edge, and the outcome is fully predictable.

Register map (3-bit address): 0 = control (read/write, reset 0x00); 1 = rising capture (read-only); 2 = falling capture (read-only); 3 = run register (read/write, reset 0xFF); 4 = overflow flag in bit 0. Control fields: [1:0] tick select, [3:2] clear edge, [4] capture mode, [5] overflow enable, [6] interrupt enable, [7] reads 0.

Top module: `cap_interval_timer`

## Requirements
- R1: After reset: control reads 0x00, both capture registers read 0x00, the run register reads 0xFF, the overflow flag reads 0, and `irq` is 0.
- R2: The counter adds one on each tick. A tick occurs every 64, 32, 4 or 2 system clocks for tick select 00, 01, 10 or 11. The counter wraps after 256 ticks, so overflows repeat every 256 tick periods.
- R3: While bit 0 of the run register (address 3) is 0, the counter holds its value. Captures and clears still act.
- R4: A rising edge of the internal capture signal loads the counter value into the rising capture register (address 1). A falling edge loads it into the falling capture register (address 2). The action takes place on the third clock edge after the pin changes, because the pin passes through two synchronizer flops and one edge-detect flop.
- R5: Clear-edge field [3:2]: 00 none, 01 rising, 10 falling, 11 both. A selected edge sets the counter to 0 in place of a tick. A capture on the same edge stores the value from before the clear.
- R6: The internal capture signal is the pin ANDed with control bit 4. In interval mode the pin has no effect on the capture registers. Setting bit 4 while the pin is high gives a rising edge, and clearing bit 4 while the pin is high gives a falling edge.
- R7: A wrap sets the flag (address 4, bit 0) only when control bit 5 is 1. Writing 0 to bit 0 clears the flag and writing 1 has no effect. A set in the same cycle as a clear wins.
- R8: `irq` is 1 exactly when the flag is 1 and control bit 6 is 1.
- R9: The counter has no bus address. Addresses 5 to 7 read 0x00, and writes to the capture registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cap_pin | input | 1 | Asynchronous capture input |
| ovf_flag | output | 1 | Overflow request flag |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker checks these behaviours on every cycle:
- the counter steps by exactly one per enabled tick;
- the counter holds when neither a tick nor a clear occurs;
- a selected edge leaves it at zero;
- each capture register takes the counter's value from the cycle of its edge;
- no edges occur while interval mode is steady;
- the overflow flag is set, held and cleared correctly, including the rule that a set wins;
- `irq` never rises without the flag.

Some behaviours only the bench scenarios can show. These are:
- the exact tick period for each select code, measured between overflows;
- the three-cycle latency from pin to capture, which the bench infers from capture differences;
- the clear timing triggered by a mode change;
- the reset and read-back values at the bus.

// File: rtl/cit_pkg.sv
// Package: shared register addresses, control-register layout and clear-edge codes
// for the input capture interval timer. Assumes an 8-bit data bus.
package cit_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CAPR = 3'd1;
    localparam logic [ADDR_W-1:0] A_CAPF = 3'd2;
    localparam logic [ADDR_W-1:0] A_RUN  = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;

    localparam logic [DATA_W-1:0] RUN_RESET = 8'hFF;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_RISE = 2'b01,
        CLR_FALL = 2'b10,
        CLR_BOTH = 2'b11
    } clr_sel_e;

    typedef struct packed {
        logic     rsvd;
        logic     irq_en;
        logic     ovf_en;
        logic     cap_mode;
        clr_sel_e clr_sel;
        logic [1:0] tick_sel;
    } ctrl_t;

endpackage

// File: rtl/cit_prescaler.sv
// Module: cit_prescaler
// Free-running divider that produces a one-cycle tick every 2**Lk clocks, where the
// exponent is picked by sel. Assumes each exponent is between 1 and PRE_W.
module cit_prescaler #(
    parameter int PRE_W = 6,
    parameter int LOG0  = 6,
    parameter int LOG1  = 5,
    parameter int LOG2  = 2,
    parameter int LOG3  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       tick
);

    localparam int NSEL = 4;

    logic [PRE_W-1:0] pre_q;
    logic [NSEL-1:0]  tap;

    // Advance the divider every cycle; it never stops.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // One tap per select code: high when the low LG bits are all ones.
    for (genvar g = 0; g < NSEL; g++) begin : g_tap
        localparam int LG = (g == 0) ? LOG0 : (g == 1) ? LOG1 : (g == 2) ? LOG2 : LOG3;
        assign tap[g] = &pre_q[LG-1:0];
    end

    // Route the chosen tap to the counter.
    assign tick = tap[sel];

endmodule

// File: rtl/cit_edge_sync.sv
// Module: cit_edge_sync
// Synchronizes an asynchronous pin through STAGES flops, gates the result with an
// enable level, and reports one-cycle rising and falling pulses of the gated signal.
// Assumes STAGES >= 2. A change of the gate therefore shows up as an edge.
module cit_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic gate,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] sh_q;
    logic              sig;
    logic              prev_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], pin};
    end

    // Gated internal capture signal.
    assign sig = sh_q[STAGES-1] & gate;

    // Remember last cycle's gated signal for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    // Edge pulses, valid for one cycle.
    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;

endmodule

// File: rtl/cit_counter.sv
// Module: cit_counter
// The hidden up-counter with its two capture registers. A selected edge clears the
// counter in place of a tick, and a capture on the same edge keeps the old value.
// Assumes rise and fall are single-cycle pulses that never occur together.
module cit_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             clr_on_rise,
    input  logic             clr_on_fall,
    input  logic             rise,
    input  logic             fall,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_r,
    output logic [CNT_W-1:0] cap_f,
    output logic             step,
    output logic             clr_hit,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Decode the count and clear events of this cycle.
    assign step    = tick & run;
    assign clr_hit = (rise & clr_on_rise) | (fall & clr_on_fall);
    assign wrap    = step & ~clr_hit & (cnt == CNT_MAX);

    // Counter: a clear beats a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clr_hit) cnt <= '0;
        else if (step)    cnt <= cnt + 1'b1;
    end

    // Rising-edge capture of the pre-update value.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap_r <= '0;
        else if (rise) cap_r <= cnt;
    end

    // Falling-edge capture of the pre-update value.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap_f <= '0;
        else if (fall) cap_f <= cnt;
    end

endmodule

// File: rtl/cap_interval_timer.sv
// Module: cap_interval_timer
// Top level: register bus, prescaler, pin synchronizer and counter. Reads are
// combinational and a write takes effect on the clock edge where bus_we is high.
// Assumes an active-low synchronous reset and a single clock domain apart from cap_pin.
module cap_interval_timer
    import cit_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_W       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_pin,
    output logic              ovf_flag,
    output logic              irq
);

    localparam int CNT_W = DATA_W;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] run_q;
    logic              flag_q;
    logic              wr_ctrl, wr_run, wr_flag, flag_clr_wr;
    logic              tick, rise, fall;
    logic [CNT_W-1:0]  cnt, cap_r, cap_f;
    logic              step, clr_hit, wrap;

    // Write strobes per register.
    assign wr_ctrl     = bus_we && (bus_addr == A_CTRL);
    assign wr_run      = bus_we && (bus_addr == A_RUN);
    assign wr_flag     = bus_we && (bus_addr == A_FLAG);
    assign flag_clr_wr = wr_flag && !bus_wdata[0];

    // Control register; the reserved bit always stores 0.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'({1'b0, bus_wdata[DATA_W-2:0]});
    end

    // Run register; bit 0 enables counting.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= RUN_RESET;
        else if (wr_run) run_q <= bus_wdata;
    end

    // Overflow flag: a set wins over a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag_q <= 1'b0;
        else if (wrap && ctrl_q.ovf_en)  flag_q <= 1'b1;
        else if (flag_clr_wr)            flag_q <= 1'b0;
    end

    cit_prescaler #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (ctrl_q.tick_sel),
        .tick  (tick)
    );

    cit_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cap_pin),
        .gate  (ctrl_q.cap_mode),
        .rise  (rise),
        .fall  (fall)
    );

    cit_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .run         (run_q[0]),
        .clr_on_rise (ctrl_q.clr_sel[0]),
        .clr_on_fall (ctrl_q.clr_sel[1]),
        .rise        (rise),
        .fall        (fall),
        .cnt         (cnt),
        .cap_r       (cap_r),
        .cap_f       (cap_f),
        .step        (step),
        .clr_hit     (clr_hit),
        .wrap        (wrap)
    );

    // Read multiplexer; the counter has no address.
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_CAPR:  bus_rdata = cap_r;
            A_CAPF:  bus_rdata = cap_f;
            A_RUN:   bus_rdata = run_q;
            A_FLAG:  bus_rdata = {{(DATA_W-1){1'b0}}, flag_q};
            default: bus_rdata = '0;
        endcase
    end

    // Request outputs.
    assign ovf_flag = flag_q;
    assign irq      = flag_q & ctrl_q.irq_en;

endmodule

// File: rtl/cit_checker.sv
// Module: cit_checker
// Cycle-by-cycle properties of the timer, attached to the top module by bind.
module cit_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cap_r,
    input logic [CNT_W-1:0] cap_f,
    input logic             step,
    input logic             clr_hit,
    input logic             rise,
    input logic             fall,
    input logic             mode,
    input logic             wrap,
    input logic             ovf_en,
    input logic             flag,
    input logic             flag_clr_wr,
    input logic             irq
);

    // R2: one enabled tick adds exactly one.
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr_hit) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R3: with no tick and no clear, the counter holds.
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr_hit) |=> $stable(cnt));

    // R4: the capture registers take the pre-edge counter value.
    a_r4_rise_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (cap_r == $past(cnt)));
    a_r4_fall_cap: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (cap_f == $past(cnt)));

    // R5: a selected edge leaves the counter at zero.
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> (cnt == '0));

    // R6: in steady interval mode no capture edge appears.
    a_r6_interval_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && !$past(mode)) |-> (!rise && !fall));

    // R7: an enabled wrap sets the flag, even when a clear is written.
    a_r7_set_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ovf_en) |=> flag);

    // R7: the flag holds unless software writes 0.
    a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr_wr) |=> flag);

    // R7: the flag never rises without an enabled wrap.
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(wrap && ovf_en)) |=> !flag);

    // R8: the interrupt needs the flag.
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

endmodule

bind cap_interval_timer cit_checker #(.CNT_W(8)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt         (cnt),
    .cap_r       (cap_r),
    .cap_f       (cap_f),
    .step        (step),
    .clr_hit     (clr_hit),
    .rise        (rise),
    .fall        (fall),
    .mode        (ctrl_q.cap_mode),
    .wrap        (wrap),
    .ovf_en      (ctrl_q.ovf_en),
    .flag        (flag_q),
    .flag_clr_wr (flag_clr_wr),
    .irq         (irq)
);

// File: tb/cap_interval_timer_test.sv
// Bench for cap_interval_timer: a table of tick-select vectors, then directed tests.
module cap_interval_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;
    // {tick select, expected cycles between overflows}
    localparam int VEC [4][2] = '{'{0, 16384}, '{1, 8192}, '{2, 1024}, '{3, 512}};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0;
    logic       ovf_flag, irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    cap_interval_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .cap_pin   (cap_pin),
        .ovf_flag  (ovf_flag),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Raise the pin, keep it high for 'hi' cycles, drop it, then settle.
    task automatic pulse(input int hi);
        cap_pin = 1'b1;
        idle(hi);
        cap_pin = 1'b0;
        idle(5);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, r, f;
        int t0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset values
        rd(3'd0, v); check("R1 ctrl", v, 8'h00);
        rd(3'd1, v); check("R1 capr", v, 8'h00);
        rd(3'd2, v); check("R1 capf", v, 8'h00);
        rd(3'd3, v); check("R1 run", v, 8'hFF);
        rd(3'd4, v); check("R1 flag", v, 8'h00);
        check("R1 irq", irq, 0);

        // R9 hidden counter, read-only captures
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), v); check("R9 unmapped read", v, 0);
        end
        wr(3'd1, 8'hAA);
        rd(3'd1, v); check("R9 capr write ignored", v, 8'h00);

        // R6 interval mode ignores the pin
        pulse(10);
        rd(3'd1, v); check("R6 interval capr", v, 0);
        rd(3'd2, v); check("R6 interval capf", v, 0);

        // R2 table of tick periods, interval mode, overflow enabled
        for (int k = 0; k < 4; k++) begin
            wr(3'd0, 8'h20 | 8'(VEC[k][0]));
            wr(3'd4, 8'h00);
            while (!ovf_flag) @(negedge clk);
            t0 = cyc;
            wr(3'd4, 8'h00);
            while (!ovf_flag) @(negedge clk);
            check($sformatf("R2 period sel %0d", VEC[k][0]), cyc - t0, VEC[k][1]);
            check("R8 irq off with enable clear", irq, 0);
        end
        wr(3'd4, 8'h00);

        // R4 capture difference: 40 cycles apart at a tick every 2 clocks
        wr(3'd0, 8'h13);
        pulse(40);
        rd(3'd1, r); rd(3'd2, f);
        check("R4 fall minus rise", 8'(f - r), 20);

        // R5 clear on rising edge, fall captured 41 cycles later
        wr(3'd0, 8'h17);
        pulse(41);
        rd(3'd2, f); check("R5 clear on rise", f, 20);

        // R5 clear on both edges
        wr(3'd0, 8'h1F);
        cap_pin = 1'b1; idle(41);
        cap_pin = 1'b0; idle(41);
        cap_pin = 1'b1; idle(5);
        rd(3'd2, f); check("R5 both fall", f, 20);
        rd(3'd1, r); check("R5 both rise", r, 20);
        cap_pin = 1'b0; idle(5);

        // R3 run bit 0 cleared freezes the counter
        wr(3'd3, 8'hFE);
        rd(3'd3, v); check("R3 run readback", v, 8'hFE);
        wr(3'd0, 8'h13);
        pulse(40);
        rd(3'd1, r); rd(3'd2, f);
        check("R3 frozen captures equal", f, r);
        wr(3'd3, 8'hFF);

        // R6 mode change while the pin is high acts as a rising edge (clear on rise)
        wr(3'd0, 8'h07);
        cap_pin = 1'b1; idle(5);
        wr(3'd0, 8'h17);
        idle(39);
        cap_pin = 1'b0; idle(5);
        rd(3'd2, f); check("R6 mode change clears", f, 20);

        // R7 / R8 overflow gating
        wr(3'd0, 8'h03);
        wr(3'd4, 8'h00);
        idle(600);
        check("R7 no flag when disabled", ovf_flag, 0);
        wr(3'd0, 8'h23);
        idle(600);
        check("R7 flag set", ovf_flag, 1);
        check("R8 irq masked", irq, 0);
        rd(3'd4, v); check("R7 flag readback", v, 1);
        wr(3'd4, 8'h01);
        check("R7 write 1 no effect", ovf_flag, 1);
        wr(3'd4, 8'h00);
        check("R7 write 0 clears", ovf_flag, 0);
        wr(3'd0, 8'h63);
        idle(600);
        check("R8 irq raised", irq, 1);
        wr(3'd0, 8'h23);
        check("R8 irq follows enable", irq, 0);
        wr(3'd0, 8'h43);
        wr(3'd4, 8'h00);
        idle(600);
        check("R8 no irq without flag", irq, 0);
        check("R7 no flag with enable low", ovf_flag, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule